// File: doc/BRIEF.md
# I2C Device-ID Responder

This block is a companion to an I2C memory target. It listens on the already-filtered SCL and SDA lines. It also watches the start and stop pulses that the bus front end shares with the memory target. It answers only the reserved identification sequence, which runs in this order:

1. A start and the reserved write byte F8h.
2. The ordinary device address word, whose type code and strap bits must match.
3. A repeated start and the reserved read byte F9h.
4. Any number of identifier bytes, until the controller declines one.

The block never touches the memory array. Its only bus action is an open-drain pull-down request on SDA.

While the block owns a transaction it raises a busy flag, and the memory target ignores the bus while that flag is high. The block has no data stream at its edge, so there is no valid/ready pair. All pins are plain control and status signals, sampled every clock.

The 24-bit identifier is built from three parameter fields:

| Field | Width | Default |
|---|---|---|
| Maker | 12 bits | 00Ah |
| Size code | 4 bits | 5h |
| Part | 8 bits | 10h |

With the defaults the bytes on the wire are 00h, A5h and 10h.

Top module: `i2cid_responder`

## Requirements
- R1: After reset, sda_pull and id_busy are both low.
- R2: After a start, the first byte is acknowledged only if it equals F8h. Any other value gets no pull-down in the ninth slot, and id_busy stays low.
- R3: The second byte is acknowledged only when bits [7:4] equal 1010b and bits [3:1] equal strap_addr. Bit 0 (read/write) is ignored. On a mismatch there is no acknowledge and the block returns to idle.
- R4: After the second byte, a repeated start followed by F9h is acknowledged. Any other byte there gets no acknowledge and returns the block to idle.
- R5: The identifier bytes go out in the order 00h, A5h, 10h, each most significant bit first. sda_pull high means a 0 bit.
- R6: If the controller acknowledges the third byte, the next byte sent is the first byte again. A not-acknowledge after any byte returns the block to idle with id_busy low.
- R7: A stop pulse in any phase returns the block to idle on the next clock, with sda_pull released.
- R8: sda_pull changes only while SCL is low, except when it is released by a start or stop pulse. sda_pull stays low during the controller's acknowledge slot after each identifier byte.
- R9: id_busy rises at the acknowledge of F8h and stays high until the block returns to idle. sda_pull is never high while id_busy is low.
- R10: A start pulse arriving anywhere other than the wait for the repeated start releases SDA and restarts matching from the F8h byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level, as seen on the wire |
| start_det | input | 1 | One-cycle pulse when a start or repeated start is seen |
| stop_det | input | 1 | One-cycle pulse when a stop is seen |
| strap_addr | input | STRAP_W | Board strap bits that the address word must match |
| sda_pull | output | 1 | Request to pull SDA low (open drain) |
| id_busy | output | 1 | High while the block owns the current transaction |

## Verification
The full sequence is run with several strap values and with both settings of the read/write bit. This shows that the address check compares the strap bits and ignores bit 0.

Random address words, most of them wrong, separate a correct acknowledge from a spurious one. Reads of one to eight bytes show the wrap back to 00h after the third byte, and show that the sequence ends on the first not-acknowledge. A wrong first byte, a wrong F9h slot, a stop part-way through a byte, and a fresh start in the address phase each exercise a different path back to idle.

// File: rtl/i2cid_pkg.sv
package i2cid_pkg;
  localparam int ID_BYTES = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RSVW,
    PH_DEVW,
    PH_WAITRS,
    PH_RSVR,
    PH_TX
  } phase_e;
endpackage

// File: rtl/i2cid_scl_edge.sv
module i2cid_scl_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic rise,
  output logic fall
);
  logic scl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_i;

  assign rise = scl_i & ~scl_q;
  assign fall = ~scl_i & scl_q;
endmodule

// File: rtl/i2cid_idsel.sv
module i2cid_idsel #(
  parameter logic [11:0] MFR_ID  = 12'h00A,
  parameter logic [3:0]  DENSITY = 4'h5,
  parameter logic [7:0]  PRODUCT = 8'h10,
  parameter int          NBYTES  = 3
) (
  input  logic [$clog2(NBYTES)-1:0] idx,
  output logic [7:0]                id_byte
);
  localparam int          IDX_W   = $clog2(NBYTES);
  localparam int          SLOTS   = 1 << IDX_W;
  localparam logic [23:0] ID_WORD = {MFR_ID, DENSITY, PRODUCT};

  logic [7:0] table_q [SLOTS];

  // One table entry per index value; unused indices read as zero.
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NBYTES) begin : g_used
      assign table_q[i] = ID_WORD[23-8*i -: 8];
    end else begin : g_spare
      assign table_q[i] = 8'h00;
    end
  end

  assign id_byte = table_q[idx];
endmodule

// File: rtl/i2cid_responder.sv
module i2cid_responder
  import i2cid_pkg::*;
#(
  parameter int          STRAP_W   = 3,
  parameter logic [3:0]  TYPE_CODE = 4'hA,
  parameter logic [7:0]  RSV_WR    = 8'hF8,
  parameter logic [7:0]  RSV_RD    = 8'hF9,
  parameter logic [11:0] MFR_ID    = 12'h00A,
  parameter logic [3:0]  DENSITY   = 4'h5,
  parameter logic [7:0]  PRODUCT   = 8'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic               sda_pull,
  output logic               id_busy
);
  localparam int IDX_W = $clog2(ID_BYTES);

  phase_e             phase, nxt_phase;
  logic [3:0]         bitcnt;
  logic [7:0]         shreg;
  logic               ack_slot, m_ack, byte_ok;
  logic [IDX_W-1:0]   idx, idx_nx;
  logic [7:0]         cur_byte, nxt_byte;
  logic               scl_rise, scl_fall;

  i2cid_scl_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .rise  (scl_rise),
    .fall  (scl_fall)
  );

  i2cid_idsel #(.MFR_ID(MFR_ID), .DENSITY(DENSITY), .PRODUCT(PRODUCT), .NBYTES(ID_BYTES))
    u_cur (.idx(idx), .id_byte(cur_byte));

  i2cid_idsel #(.MFR_ID(MFR_ID), .DENSITY(DENSITY), .PRODUCT(PRODUCT), .NBYTES(ID_BYTES))
    u_nxt (.idx(idx_nx), .id_byte(nxt_byte));

  assign idx_nx = (idx == IDX_W'(ID_BYTES - 1)) ? '0 : idx + 1'b1;

  // Decide whether the byte just received is acknowledged, and where it leads.
  always_comb begin
    byte_ok   = 1'b0;
    nxt_phase = PH_IDLE;
    case (phase)
      PH_RSVW: begin
        byte_ok   = (shreg == RSV_WR);
        nxt_phase = PH_DEVW;
      end
      PH_DEVW: begin
        byte_ok   = (shreg[7:4] == TYPE_CODE) && (shreg[STRAP_W:1] == strap_addr);
        nxt_phase = PH_WAITRS;
      end
      PH_RSVR: begin
        byte_ok   = (shreg == RSV_RD);
        nxt_phase = PH_TX;
      end
      default: ;
    endcase
  end

  assign id_busy = (phase == PH_DEVW) || (phase == PH_WAITRS) ||
                   (phase == PH_RSVR) || (phase == PH_TX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ack_slot <= 1'b0;
      m_ack    <= 1'b0;
      idx      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      bitcnt   <= '0;
      ack_slot <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      phase    <= (phase == PH_WAITRS) ? PH_RSVR : PH_RSVW;
      bitcnt   <= '0;
      ack_slot <= 1'b0;
      idx      <= '0;
      sda_pull <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (ack_slot) begin
          bitcnt <= 4'd9;
        end else if (phase == PH_TX) begin
          if (bitcnt == 4'd8) m_ack <= ~sda_i;
          if (bitcnt < 4'd9)  bitcnt <= bitcnt + 4'd1;
        end else if (phase != PH_WAITRS && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_i};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (scl_fall) begin
        if (ack_slot) begin
          // End of our own acknowledge slot.
          if (bitcnt == 4'd9) begin
            ack_slot <= 1'b0;
            bitcnt   <= '0;
            sda_pull <= (phase == PH_TX) ? ~cur_byte[7] : 1'b0;
          end
        end else if (phase == PH_TX) begin
          if (bitcnt == 4'd8) begin
            sda_pull <= 1'b0;
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if (m_ack) begin
              idx      <= idx_nx;
              sda_pull <= ~nxt_byte[7];
            end else begin
              phase <= PH_IDLE;
            end
          end else if (bitcnt != 4'd0) begin
            sda_pull <= ~cur_byte[~bitcnt[2:0]];
          end
        end else if (bitcnt == 4'd8) begin
          if (byte_ok) begin
            phase    <= nxt_phase;
            ack_slot <= 1'b1;
            sda_pull <= 1'b1;
          end else begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2cid_checker.sv
module i2cid_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic id_busy
);
  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!id_busy && !sda_pull));

  assert_start_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  assert_pull_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> id_busy);

  assert_change_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_i);

  assert_busy_rise_at_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_busy) |-> (sda_pull && !scl_i));
endmodule

bind i2cid_responder i2cid_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_pull  (sda_pull),
  .id_busy   (id_busy)
);

// File: tb/sim_i2cid_responder.sv
module sim_i2cid_responder;
  localparam int HP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       start_det = 1'b0;
  logic       stop_det = 1'b0;
  logic [2:0] strap = 3'd0;
  logic       sda_pull, id_busy;
  wire        sda = sda_m & ~sda_pull;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  i2cid_responder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_addr (strap),
    .sda_pull   (sda_pull),
    .id_busy    (id_busy)
  );

  function automatic logic [7:0] exp_id(int k);
    case (k % 3)
      0:       return 8'h00;
      1:       return 8'hA5;
      default: return 8'h10;
    endcase
  endfunction

  function automatic bit dw_match(logic [7:0] dw, logic [2:0] s);
    return (dw[7:4] == 4'hA) && (dw[3:1] == s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HP); scl = 1'b1; tick(HP);
    sda_m = 1'b0; start_det = 1'b1; tick(1); start_det = 1'b0;
    tick(HP); scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; tick(HP); scl = 1'b1; tick(HP);
    sda_m = 1'b1; stop_det = 1'b1; tick(1); stop_det = 1'b0; tick(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HP); scl = 1'b1; tick(HP); scl = 1'b0;
    end
    sda_m = 1'b1; tick(HP); scl = 1'b1; tick(HP / 2);
    acked = ~sda;
    tick(HP - HP / 2); scl = 1'b0; tick(HP);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b, output bit pulled);
    for (int i = 7; i >= 0; i--) begin
      tick(HP); scl = 1'b1; tick(HP / 2); b[i] = sda; tick(HP - HP / 2); scl = 1'b0;
    end
    sda_m = ~mack; tick(HP); scl = 1'b1; tick(HP / 2);
    pulled = sda_pull;
    tick(HP - HP / 2); scl = 1'b0; tick(1); sda_m = 1'b1; tick(HP);
  endtask

  // Full identification read of n bytes, then a stop.
  task automatic id_read(input logic [7:0] dw, input int n);
    bit ack; bit pulled; logic [7:0] b;
    bus_start();
    send_byte(8'hF8, ack);
    chk(ack, "R2", "reserved write ack", ack, 1);
    send_byte(dw, ack);
    chk(ack == dw_match(dw, strap), "R3", "address word ack", ack, dw_match(dw, strap));
    if (!dw_match(dw, strap)) begin
      chk(!id_busy, "R3", "busy after mismatch", id_busy, 0);
      bus_stop();
      return;
    end
    bus_start();
    send_byte(8'hF9, ack);
    chk(ack, "R4", "reserved read ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k != n - 1, b, pulled);
      chk(b == exp_id(k), (k >= 3) ? "R6" : "R5", "id byte", b, exp_id(k));
      chk(!pulled, "R8", "release in ack slot", pulled, 0);
    end
    chk(!id_busy && !sda_pull, "R6", "idle after nack", {id_busy, sda_pull}, 0);
    bus_stop();
  endtask

  initial begin
    bit ack;
    void'($urandom(32'd2024));
    tick(3);
    chk(!sda_pull && !id_busy, "R1", "reset outputs", {sda_pull, id_busy}, 0);
    rst_n = 1'b1;
    tick(4);

    // Directed full reads (R5, R6 wrap).
    strap = 3'd5;
    id_read({4'hA, 3'd5, 1'b0}, 3);
    id_read({4'hA, 3'd5, 1'b1}, 7);

    // Wrong first byte (R2).
    bus_start();
    send_byte(8'hF9, ack);
    chk(!ack && !id_busy, "R2", "wrong first byte", {ack, id_busy}, 0);
    bus_stop();

    // Wrong type code (R3).
    id_read({4'hB, 3'd5, 1'b0}, 1);

    // Wrong byte after repeated start (R4).
    bus_start();
    send_byte(8'hF8, ack);
    chk(id_busy, "R9", "busy after reserved ack", id_busy, 1);
    send_byte({4'hA, 3'd5, 1'b0}, ack);
    bus_start();
    send_byte(8'hFA, ack);
    chk(!ack && !id_busy, "R4", "wrong read byte", {ack, id_busy}, 0);
    bus_stop();

    // Stop in the middle of the address word (R7).
    bus_start();
    send_byte(8'hF8, ack);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; tick(HP); scl = 1'b1; tick(HP); scl = 1'b0;
    end
    bus_stop();
    chk(!id_busy && !sda_pull, "R7", "idle after stop", {id_busy, sda_pull}, 0);

    // Fresh start during the address phase restarts matching (R10).
    bus_start();
    send_byte(8'hF8, ack);
    bus_start();
    chk(!id_busy, "R10", "busy after fresh start", id_busy, 0);
    send_byte(8'hF8, ack);
    chk(ack, "R10", "reserved ack after restart", ack, 1);
    send_byte({4'hA, 3'd5, 1'b1}, ack);
    chk(ack, "R10", "address ack after restart", ack, 1);
    bus_stop();

    // Random straps, address words and read lengths.
    for (int it = 0; it < 24; it++) begin
      logic [7:0] dw;
      strap = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) dw = {4'hA, strap, 1'($urandom_range(0, 1))};
      else                           dw = 8'($urandom_range(0, 255));
      id_read(dw, $urandom_range(1, 8));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule